// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit performs the bit-level operations of a 32-bit integer pipeline in a single datapath. These are rotate right by an immediate or by a register amount, bitfield extract, bitfield insert, swapping the two bytes inside each halfword, and sign extension of a byte or a halfword. A three-bit operation code picks the operation. The pipeline feeds two source operands: the value to operate on and, for insert, the prior destination value. It also feeds an immediate amount, a register amount, and a field position and size. The unit returns one result word and a flag that marks an ill-formed field.

Generation of the field mask is per bit, so a 32-bit field at position 0 yields a full mask. The span sum carries an extra bit, so no count can wrap. Fields that run past bit 31 still give a defined result, and the flag is raised. An output register, on by default through `OUT_REG`, adds one cycle of latency and clears to zero on reset.

Top module: `bmu_top`

## Requirements
- R1: With code 1 (rotate by register), only `amtReg[4:0]` sets the amount. Bits 31..5 of `amtReg` have no effect on the result.
- R2: Codes 0 (amount `amtImm`) and 1 rotate `srcVal` right by n, giving (srcVal >> n) | (srcVal << (32 − n)).
- R3: A rotate amount of zero returns `srcVal` unchanged.
- R4: With code 2 (extract), the result is `srcVal >> fieldPos` keeping the low `fieldSize` bits, and every higher bit is zero.
- R5: With code 3 (insert), result bits at positions fieldPos..fieldPos+fieldSize−1 take `srcVal` bits 0..fieldSize−1. All other bits take `oldVal`, so a size of 0 returns `oldVal`.
- R6: With `fieldSize` = 32 and `fieldPos` = 0, extract returns `srcVal` and insert returns `srcVal` (full-width mask).
- R7: Code 4 exchanges bytes 0 and 1 and bytes 2 and 3 of `srcVal`, so 0xAABBCCDD gives 0xBBAADDCC.
- R8: Code 5 copies `srcVal[7]` into bits 31..8 and keeps bits 7..0.
- R9: Code 6 copies `srcVal[15]` into bits 31..16 and keeps bits 15..0.
- R10: `fieldErr` is 1 only for codes 2 and 3 when fieldPos + fieldSize > 32. The result then follows the same bitwise rules as R4 and R5, with bits beyond 31 dropped. Other codes keep `fieldErr` at 0 whatever the field inputs are.
- R11: Code 7 gives a zero result with `fieldErr` at 0.
- R12: With `OUT_REG` = 1, `resultOut` and `fieldErr` reflect the inputs present at the previous rising clock edge. While `rstN` is low, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low asynchronous reset |
| opSel | input | 3 | Operation code (0..7) |
| srcVal | input | 32 | Source operand |
| oldVal | input | 32 | Prior destination value used by insert |
| amtImm | input | 5 | Immediate rotate amount |
| amtReg | input | 32 | Register rotate amount, low 5 bits used |
| fieldPos | input | 5 | Field start bit |
| fieldSize | input | 6 | Field width, 0..32 meaningful |
| resultOut | output | 32 | Operation result |
| fieldErr | output | 1 | Field runs past bit 31 |

## Verification
On every cycle, the bound checker enforces several invariants. A zero rotate is an identity, and extract leaves no bits above the field. An empty insert returns the old value, and swapping preserves the population count. Byte sign extension is exact, the error flag appears only for field operations, and the unused code yields zero. Exact rotate values, the insensitivity of the register amount to its upper bits, and the overflow-free full mask need the bench's vectors and reference model. The out-of-range field results and the one-cycle latency with reset clearing also rely on the bench; its sweep covers every position and size with random operands.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [2:0] {
    OP_ROT_IMM   = 3'd0,
    OP_ROT_REG   = 3'd1,
    OP_FIELD_EXT = 3'd2,
    OP_FIELD_INS = 3'd3,
    OP_SWAP_HALF = 3'd4,
    OP_SEXT_BYTE = 3'd5,
    OP_SEXT_HALF = 3'd6,
    OP_NONE      = 3'd7
  } bmuOp_e;

  // one-hot result selects plus the rotate amount source
  typedef struct packed {
    logic useRegAmt;
    logic selRot;
    logic selExt;
    logic selIns;
    logic selSwap;
    logic selSextB;
    logic selSextH;
  } bmuStrobe_t;

endpackage

// File: rtl/bmu_rotr.sv
module bmu_rotr #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] dataOut
);
  // shifting a doubled word right wraps the low bits into the top
  logic [2*DATA_W-1:0] doubled;
  assign doubled = {dataIn, dataIn} >> amt;
  assign dataOut = doubled[DATA_W-1:0];
endmodule

// File: rtl/bmu_fieldmask.sv
module bmu_fieldmask #(
  parameter int DATA_W = 32,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int SIZE_W = AMT_W + 1
) (
  input  logic [AMT_W-1:0]  pos,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] lowMask,
  output logic [DATA_W-1:0] placedMask
);
  // a per-bit compare never forms 2**size, so size == DATA_W cannot overflow
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign lowMask[i] = (SIZE_W'(i) < size);
  end
  assign placedMask = lowMask << pos;
endmodule

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int SIZE_W = AMT_W + 1
) (
  input  logic [2:0]        opSel,
  input  logic [AMT_W-1:0]  fieldPos,
  input  logic [SIZE_W-1:0] fieldSize,
  output bmuStrobe_t        strb,
  output logic              fieldErr
);
  bmuOp_e op;
  logic [SIZE_W:0] span;

  assign op = bmuOp_e'(opSel);

  always_comb begin
    strb = '0;
    unique case (op)
      OP_ROT_IMM:   strb.selRot = 1'b1;
      OP_ROT_REG:   begin strb.selRot = 1'b1; strb.useRegAmt = 1'b1; end
      OP_FIELD_EXT: strb.selExt = 1'b1;
      OP_FIELD_INS: strb.selIns = 1'b1;
      OP_SWAP_HALF: strb.selSwap = 1'b1;
      OP_SEXT_BYTE: strb.selSextB = 1'b1;
      OP_SEXT_HALF: strb.selSextH = 1'b1;
      default:      strb = '0;
    endcase
  end

  // one spare bit keeps pos + size from wrapping
  assign span     = {2'b00, fieldPos} + {1'b0, fieldSize};
  assign fieldErr = (strb.selExt | strb.selIns) && (span > (SIZE_W+1)'(DATA_W));
endmodule

// File: rtl/bmu_dpath.sv
module bmu_dpath
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int SIZE_W = AMT_W + 1,
  localparam int HALVES = DATA_W / 16
) (
  input  bmuStrobe_t        strb,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] oldVal,
  input  logic [AMT_W-1:0]  amtImm,
  input  logic [AMT_W-1:0]  amtRegLow,
  input  logic [AMT_W-1:0]  fieldPos,
  input  logic [SIZE_W-1:0] fieldSize,
  output logic [DATA_W-1:0] result
);
  logic [AMT_W-1:0]  rotAmt;
  logic [DATA_W-1:0] rotOut, lowMask, placedMask;
  logic [DATA_W-1:0] extOut, insOut, swapOut, sextBOut, sextHOut;

  assign rotAmt = strb.useRegAmt ? amtRegLow : amtImm;

  bmu_rotr #(.DATA_W(DATA_W)) u_rotr (
    .dataIn (srcVal),
    .amt    (rotAmt),
    .dataOut(rotOut)
  );

  bmu_fieldmask #(.DATA_W(DATA_W)) u_mask (
    .pos       (fieldPos),
    .size      (fieldSize),
    .lowMask   (lowMask),
    .placedMask(placedMask)
  );

  assign extOut = (srcVal >> fieldPos) & lowMask;
  assign insOut = (oldVal & ~placedMask) | ((srcVal << fieldPos) & placedMask);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign swapOut[16*h +: 8]     = srcVal[16*h+8 +: 8];
    assign swapOut[16*h+8 +: 8]   = srcVal[16*h +: 8];
  end

  assign sextBOut = {{(DATA_W-8){srcVal[7]}}, srcVal[7:0]};
  assign sextHOut = {{(DATA_W-16){srcVal[15]}}, srcVal[15:0]};

  // and-or select: an empty strobe set gives zero
  assign result = ({DATA_W{strb.selRot}}   & rotOut)
                | ({DATA_W{strb.selExt}}   & extOut)
                | ({DATA_W{strb.selIns}}   & insOut)
                | ({DATA_W{strb.selSwap}}  & swapOut)
                | ({DATA_W{strb.selSextB}} & sextBOut)
                | ({DATA_W{strb.selSextH}} & sextHOut);
endmodule

// File: rtl/bmu_top.sv
module bmu_top
  import bmu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int SIZE_W = AMT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] oldVal,
  input  logic [AMT_W-1:0]  amtImm,
  input  logic [DATA_W-1:0] amtReg,
  input  logic [AMT_W-1:0]  fieldPos,
  input  logic [SIZE_W-1:0] fieldSize,
  output logic [DATA_W-1:0] resultOut,
  output logic              fieldErr
);
  bmuStrobe_t        strb;
  logic              errComb;
  logic [DATA_W-1:0] resComb;
  logic [DATA_W-AMT_W-1:0] unusedAmtHigh;

  assign unusedAmtHigh = amtReg[DATA_W-1:AMT_W];

  bmu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .opSel    (opSel),
    .fieldPos (fieldPos),
    .fieldSize(fieldSize),
    .strb     (strb),
    .fieldErr (errComb)
  );

  bmu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .strb     (strb),
    .srcVal   (srcVal),
    .oldVal   (oldVal),
    .amtImm   (amtImm),
    .amtRegLow(amtReg[AMT_W-1:0]),
    .fieldPos (fieldPos),
    .fieldSize(fieldSize),
    .result   (resComb)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resultOut <= '0;
        fieldErr  <= 1'b0;
      end else begin
        resultOut <= resComb;
        fieldErr  <= errComb;
      end
    end
  end else begin : g_comb
    assign resultOut = resComb;
    assign fieldErr  = errComb;
  end
endmodule

// File: rtl/bmu_check.sv
module bmu_check
  import bmu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int SIZE_W = AMT_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opSel,
  input logic [DATA_W-1:0] srcVal,
  input logic [DATA_W-1:0] oldVal,
  input logic [AMT_W-1:0]  amtImm,
  input logic [DATA_W-1:0] amtReg,
  input logic [AMT_W-1:0]  fieldPos,
  input logic [SIZE_W-1:0] fieldSize,
  input logic [DATA_W-1:0] resultOut,
  input logic              fieldErr
);
  // inputs aligned to the cycle in which their result is visible
  logic              refValid;
  logic [2:0]        refOp;
  logic [DATA_W-1:0] refSrc, refOld;
  logic [AMT_W-1:0]  refAmt;
  logic [SIZE_W-1:0] refSize;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refValid <= 1'b0; refOp <= 3'd7; refSrc <= '0; refOld <= '0;
        refAmt <= '0; refSize <= '0;
      end else begin
        refValid <= 1'b1; refOp <= opSel; refSrc <= srcVal; refOld <= oldVal;
        refAmt <= (opSel == 3'd1) ? amtReg[AMT_W-1:0] : amtImm;
        refSize <= fieldSize;
      end
    end
  end else begin : g_now
    assign refValid = 1'b1;
    assign refOp    = opSel;
    assign refSrc   = srcVal;
    assign refOld   = oldVal;
    assign refAmt   = (opSel == 3'd1) ? amtReg[AMT_W-1:0] : amtImm;
    assign refSize  = fieldSize;
  end

  a_r3_zero_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refOp <= 3'd1 && refAmt == '0) |-> resultOut == refSrc);

  a_r4_ext_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refOp == 3'd2 && refSize < SIZE_W'(DATA_W)) |-> (resultOut >> refSize) == '0);

  a_r5_empty_insert: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refOp == 3'd3 && refSize == '0) |-> resultOut == refOld);

  a_r7_swap_popcount: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refOp == 3'd4) |-> $countones(resultOut) == $countones(refSrc));

  a_r8_sext_byte: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refOp == 3'd5) |-> resultOut == {{(DATA_W-8){refSrc[7]}}, refSrc[7:0]});

  a_r10_flag_field_only: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && fieldErr) |-> (refOp == 3'd2 || refOp == 3'd3));

  a_r11_none_zero: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refOp == 3'd7) |-> (resultOut == '0 && !fieldErr));
endmodule

bind bmu_top bmu_check #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_check (.*);

// File: tb/sim_bmu_top.sv
`timescale 1ns/1ps
module sim_bmu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSel = 3'd5;
  logic [31:0] srcVal = 32'h80, oldVal = '0, amtReg = '0;
  logic [4:0]  amtImm = '0, fieldPos = '0;
  logic [5:0]  fieldSize = '0;
  logic [31:0] resultOut;
  logic        fieldErr;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  bmu_top u0 (.*);

  // op | src | old | amt | pos | size | expected | flag
  localparam int NV = 18;
  localparam logic [142:0] VEC [NV] = '{
    {3'd0, 32'h12345678, 32'h0, 32'd4,        5'd31, 6'd32, 32'h81234567, 1'b0}, // R2 R10
    {3'd0, 32'hDEADBEEF, 32'h0, 32'd0,        5'd0,  6'd0,  32'hDEADBEEF, 1'b0}, // R3
    {3'd1, 32'h12345678, 32'h0, 32'hFFFFFFE8, 5'd0,  6'd0,  32'h78123456, 1'b0}, // R1 R2
    {3'd1, 32'hCAFEF00D, 32'h0, 32'h00000020, 5'd0,  6'd0,  32'hCAFEF00D, 1'b0}, // R1 R3
    {3'd2, 32'hABCD1234, 32'h0, 32'd0,        5'd8,  6'd8,  32'h00000012, 1'b0}, // R4
    {3'd2, 32'hF0F0F0F0, 32'h0, 32'd0,        5'd0,  6'd32, 32'hF0F0F0F0, 1'b0}, // R6
    {3'd3, 32'h000000AB, 32'hFFFFFFFF, 32'd0, 5'd4,  6'd8,  32'hFFFFFABF, 1'b0}, // R5
    {3'd3, 32'h13579BDF, 32'h2468ACE0, 32'd0, 5'd0,  6'd32, 32'h13579BDF, 1'b0}, // R6
    {3'd3, 32'hFFFFFFFF, 32'h55AA55AA, 32'd0, 5'd5,  6'd0,  32'h55AA55AA, 1'b0}, // R5
    {3'd4, 32'hAABBCCDD, 32'h0, 32'd0,        5'd0,  6'd0,  32'hBBAADDCC, 1'b0}, // R7
    {3'd5, 32'h12345680, 32'h0, 32'd0,        5'd0,  6'd0,  32'hFFFFFF80, 1'b0}, // R8
    {3'd5, 32'hFFFFFF7F, 32'h0, 32'd0,        5'd0,  6'd0,  32'h0000007F, 1'b0}, // R8
    {3'd6, 32'h00018000, 32'h0, 32'd0,        5'd0,  6'd0,  32'hFFFF8000, 1'b0}, // R9
    {3'd6, 32'hFFFF7FFF, 32'h0, 32'd0,        5'd0,  6'd0,  32'h00007FFF, 1'b0}, // R9
    {3'd2, 32'hABCD1234, 32'h0, 32'd0,        5'd28, 6'd8,  32'h0000000A, 1'b1}, // R10
    {3'd3, 32'h000000FF, 32'h0, 32'd0,        5'd28, 6'd8,  32'hF0000000, 1'b1}, // R10
    {3'd4, 32'h01020304, 32'h0, 32'd0,        5'd30, 6'd30, 32'h02010403, 1'b0}, // R7 R10
    {3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd9, 5'd30, 6'd9,  32'h00000000, 1'b0}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] s, input logic [31:0] o,
                       input logic [31:0] a, input logic [4:0] p, input logic [5:0] z);
    opSel = op; srcVal = s; oldVal = o; amtImm = a[4:0]; amtReg = a;
    fieldPos = p; fieldSize = z;
  endtask

  function automatic logic [31:0] refRot(input logic [31:0] x, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[(i + n) % 32];
    return r;
  endfunction

  function automatic logic [31:0] refExt(input logic [31:0] x, input int p, input int z);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i < z && i + p < 32) ? x[i + p] : 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] refIns(input logic [31:0] x, input logic [31:0] o,
                                         input int p, input int z);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i >= p && i - p < z) ? x[i - p] : o[i];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12 reset result", resultOut, 32'h0);
    check("R12 reset flag", {31'b0, fieldErr}, 32'h0);
    rstN = 1'b1;

    foreach (VEC[k]) begin
      @(negedge clk);
      drive(VEC[k][142:140], VEC[k][139:108], VEC[k][107:76], VEC[k][75:44],
            VEC[k][43:39], VEC[k][38:33]);
      @(negedge clk);
      check($sformatf("table row %0d result", k), resultOut, VEC[k][32:1]);
      check($sformatf("table row %0d flag", k), {31'b0, fieldErr}, {31'b0, VEC[k][0]});
    end

    // R12 latency: new inputs not visible before the edge
    drive(3'd6, 32'h00008000, 32'h0, 32'd0, 5'd0, 6'd0);
    #1 check("R12 before edge", resultOut, 32'h0);
    @(negedge clk);
    check("R12 after edge", resultOut, 32'hFFFF8000);

    // R2 R3 R1 sweep of every rotate amount, upper register bits random
    for (int n = 0; n < 32; n++) begin
      logic [31:0] s, hi;
      s = $urandom; hi = $urandom;
      drive(3'd0, s, 32'h0, n, 5'd0, 6'd0);
      @(negedge clk);
      check("R2 immediate rotate sweep", resultOut, refRot(s, n));
      drive(3'd1, s, 32'h0, {hi[31:5], 5'(n)}, 5'd0, 6'd0);
      @(negedge clk);
      check("R1 register rotate sweep", resultOut, refRot(s, n));
    end

    // R4 R5 R10 sweep of every position and size
    for (int p = 0; p < 32; p++) begin
      for (int z = 0; z <= 32; z++) begin
        logic [31:0] s, o;
        s = $urandom; o = $urandom;
        drive(3'd2, s, o, 32'd0, 5'(p), 6'(z));
        @(negedge clk);
        check("R4 extract sweep", resultOut, refExt(s, p, z));
        check("R10 extract flag", {31'b0, fieldErr}, {31'b0, (p + z > 32)});
        drive(3'd3, s, o, 32'd0, 5'(p), 6'(z));
        @(negedge clk);
        check("R5 insert sweep", resultOut, refIns(s, o, p, z));
        check("R10 insert flag", {31'b0, fieldErr}, {31'b0, (p + z > 32)});
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule